// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block is an 8-bit control and status register that lets software arm and sequence self-programming of an on-chip program flash. Software writes the enable bit, alone or with one command bit. That write opens a short window. The next store-instruction strobe inside the window then performs the armed action:
- fill one word of the temporary page buffer,
- start a page erase,
- start a page write, or
- pulse a section read-enable.

When the lock-bit command is armed, a load-instruction strobe inside a shorter window returns either the lock byte or the fuse byte.

The block clears the enable and command bits by itself. This happens when the action is done, or when the window closes with no instruction. The CPU is held halted while an erase or write runs on the flash. The block finishes such an operation on a done handshake from the flash. It also requests a ready interrupt while the enable bit is clear. The flash array itself sits outside this block.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset all register bits read 0, `cpu_halt`, `irq` and all pulse outputs are 0. Register layout of `reg_rdata`: bit 7 interrupt enable, bits 6 and 5 always read 0, bit 4 section read-enable command, bit 3 lock-read command, bit 2 page-write command, bit 1 page-erase command, bit 0 enable.
- R2: A register write with bit 0 set arms exactly one command, chosen by priority: erase (bit 1), then write (bit 2), then lock read (bit 3), then section read-enable (bit 4). With none of these bits set, it arms a buffer fill, and no command bit reads 1. A write with bit 0 clear disarms and leaves all command bits 0.
- R3: A store strobe is accepted only in the 4 cycles after the arming write. If none arrives in that time, bit 0 and the command bits read 0 from then on.
- R4: An accepted fill store pulses `buf_wr` for one cycle, in the cycle after the strobe. It carries `buf_addr` = `z_ptr[PAGE_LSB-1:1]` and `buf_data` = `st_data`, and clears bit 0.
- R5: An accepted erase or write store pulses `op_start` in the cycle after the strobe. It drives `op_kind` 1 for erase or 2 for write, and `op_page` = `z_ptr[ZW-1:PAGE_LSB]`. `cpu_halt` rises in that same cycle.
- R6: While an erase or write is busy, `cpu_halt` stays 1 and bit 0 and the command bit keep reading 1. Register writes are ignored. A one-cycle `op_done` ends the operation, and in the following cycle halt, bit 0 and the command bit read 0.
- R7: With the lock read armed, a load strobe in the 3 cycles after the arming write pulses `ld_valid`. It returns `fuse_bits` when `z_ptr[0]`=1 and `lock_bits` when `z_ptr[0]`=0. A later load gets no response.
- R8: A register write with bit 4 set while the buffer holds filled words pulses `buf_clr` for one cycle and marks the buffer empty. A completed page write also marks it empty. A store with the section read-enable command armed pulses `op_start` with `op_kind` 3, with no halt, and disarms.
- R9: `irq` is 1 exactly when bit 7 is set, `gie` is 1 and bit 0 is clear.
- R10: A store strobe with nothing armed has no effect: no `buf_wr` and no `op_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| st_req | input | 1 | Store-instruction strobe |
| ld_req | input | 1 | Load-instruction strobe |
| z_ptr | input | ZW | Z pointer byte address |
| st_data | input | 16 | R1:R0 word for buffer fill |
| lock_bits | input | 8 | Lock byte to return |
| fuse_bits | input | 8 | Fuse byte to return |
| gie | input | 1 | Global interrupt flag |
| op_done | input | 1 | Flash erase/write finished |
| buf_wr | output | 1 | Temporary buffer write pulse |
| buf_addr | output | PAGE_LSB-1 | Buffer word index |
| buf_data | output | 16 | Buffer word data |
| buf_clr | output | 1 | Temporary buffer clear pulse |
| op_start | output | 1 | Flash operation start pulse |
| op_kind | output | 2 | 1 erase, 2 write, 3 section read-enable |
| op_page | output | ZW-PAGE_LSB | Page address |
| ld_valid | output | 1 | Lock/fuse read result valid |
| ld_data | output | 8 | Lock/fuse read result |
| cpu_halt | output | 1 | CPU halt during erase/write |
| irq | output | 1 | Ready interrupt request |

## Verification
The bench targets the edges of both windows: a store on the fourth cycle after arming and one on the fifth, and a load on the third and fourth cycles. A design with an off-by-one counter would either fill the buffer late or drop a legal store. It drives command combinations with several bits set at once, so a wrong priority shows up as the wrong bit reading back. It writes the register during a busy erase, which a design would wrongly let through and so release the halt early. It also checks that the buffer is cleared only when it holds data, and that a page write leaves it empty. Randomized fill stores with random pointer, data and delay check the index that is dropped from Z and the window cut-off across many cases.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

    typedef enum logic [2:0] {
        CMD_FILL  = 3'd0,
        CMD_ERASE = 3'd1,
        CMD_WRITE = 3'd2,
        CMD_LOCK  = 3'd3,
        CMD_REN   = 3'd4
    } cmd_e;

    localparam int IE_BIT  = 7;
    localparam int REN_BIT = 4;
    localparam int LBS_BIT = 3;
    localparam int PW_BIT  = 2;
    localparam int PE_BIT  = 1;
    localparam int EN_BIT  = 0;

    localparam logic [1:0] OP_ERASE = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;
    localparam logic [1:0] OP_REN   = 2'd3;

endpackage

// File: rtl/selfprog_cmd_decode.sv
module selfprog_cmd_decode
    import selfprog_pkg::*;
(
    input  logic [7:0] wdata,
    output cmd_e       cmd
);
    // Fixed priority among command bits; no command bit means buffer fill.
    always_comb begin
        if (wdata[PE_BIT])       cmd = CMD_ERASE;
        else if (wdata[PW_BIT])  cmd = CMD_WRITE;
        else if (wdata[LBS_BIT]) cmd = CMD_LOCK;
        else if (wdata[REN_BIT]) cmd = CMD_REN;
        else                     cmd = CMD_FILL;
    end
endmodule

// File: rtl/selfprog_window.sv
module selfprog_window #(
    parameter int ARM_WIN = 4,
    parameter int LD_WIN  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last,
    output logic ld_ok
);
    localparam int CW = $clog2(ARM_WIN + 1);
    localparam logic [CW-1:0] START  = CW'(ARM_WIN);
    localparam logic [CW-1:0] LD_MIN = CW'(ARM_WIN - LD_WIN);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                          cnt_d = START;
        else if (run && cnt_q != '0)       cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last  = (cnt_q == CW'(1));
    assign ld_ok = (cnt_q > LD_MIN);
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
    import selfprog_pkg::*;
#(
    parameter int ZW       = 16,
    parameter int PAGE_LSB = 6,
    parameter int ARM_WIN  = 4,
    parameter int LD_WIN   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [7:0]             reg_wdata,
    output logic [7:0]             reg_rdata,
    input  logic                   st_req,
    input  logic                   ld_req,
    input  logic [ZW-1:0]          z_ptr,
    input  logic [15:0]            st_data,
    input  logic [7:0]             lock_bits,
    input  logic [7:0]             fuse_bits,
    input  logic                   gie,
    input  logic                   op_done,
    output logic                   buf_wr,
    output logic [PAGE_LSB-2:0]    buf_addr,
    output logic [15:0]            buf_data,
    output logic                   buf_clr,
    output logic                   op_start,
    output logic [1:0]             op_kind,
    output logic [ZW-PAGE_LSB-1:0] op_page,
    output logic                   ld_valid,
    output logic [7:0]             ld_data,
    output logic                   cpu_halt,
    output logic                   irq
);
    localparam int AW = PAGE_LSB - 1;
    localparam int PW = ZW - PAGE_LSB;

    typedef struct packed {
        logic          ie;
        cmd_e          cmd;
        logic          en;
        logic          busy;
        logic          filled;
        logic          buf_wr;
        logic [AW-1:0] buf_addr;
        logic [15:0]   buf_data;
        logic          buf_clr;
        logic          op_start;
        logic [1:0]    op_kind;
        logic [PW-1:0] op_page;
        logic          ld_valid;
        logic [7:0]    ld_data;
    } state_t;

    state_t d, q;
    cmd_e   dec_cmd;
    logic   win_last, win_ld_ok;
    logic   wr_ok, acc_st, acc_ld, expire;

    selfprog_cmd_decode u_dec (
        .wdata (reg_wdata),
        .cmd   (dec_cmd)
    );

    selfprog_window #(.ARM_WIN(ARM_WIN), .LD_WIN(LD_WIN)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_ok && reg_wdata[EN_BIT]),
        .run   (q.en && !q.busy),
        .last  (win_last),
        .ld_ok (win_ld_ok)
    );

    always_comb begin
        // A register write wins over an instruction strobe in the same cycle.
        wr_ok  = reg_wr && !q.busy;
        acc_st = st_req && q.en && !q.busy && !reg_wr;
        acc_ld = ld_req && !st_req && q.en && !q.busy && !reg_wr
                 && (q.cmd == CMD_LOCK) && win_ld_ok;
        expire = q.en && !q.busy && !reg_wr && !acc_st && !acc_ld && win_last;

        d          = q;
        d.buf_wr   = 1'b0;
        d.buf_clr  = 1'b0;
        d.op_start = 1'b0;
        d.ld_valid = 1'b0;

        if (wr_ok) begin
            d.ie  = reg_wdata[IE_BIT];
            d.en  = reg_wdata[EN_BIT];
            d.cmd = reg_wdata[EN_BIT] ? dec_cmd : CMD_FILL;
            if (reg_wdata[REN_BIT] && q.filled) begin
                d.buf_clr = 1'b1;
                d.filled  = 1'b0;
            end
        end else if (acc_st) begin
            unique case (q.cmd)
                CMD_FILL: begin
                    d.buf_wr   = 1'b1;
                    d.buf_addr = z_ptr[PAGE_LSB-1:1];
                    d.buf_data = st_data;
                    d.filled   = 1'b1;
                    d.en       = 1'b0;
                end
                CMD_ERASE, CMD_WRITE: begin
                    d.op_start = 1'b1;
                    d.op_kind  = (q.cmd == CMD_ERASE) ? OP_ERASE : OP_WRITE;
                    d.op_page  = z_ptr[ZW-1:PAGE_LSB];
                    d.busy     = 1'b1;
                end
                CMD_REN: begin
                    d.op_start = 1'b1;
                    d.op_kind  = OP_REN;
                    d.op_page  = z_ptr[ZW-1:PAGE_LSB];
                    d.en       = 1'b0;
                    d.cmd      = CMD_FILL;
                end
                default: begin
                    d.en  = 1'b0;
                    d.cmd = CMD_FILL;
                end
            endcase
        end else if (acc_ld) begin
            d.ld_valid = 1'b1;
            d.ld_data  = z_ptr[0] ? fuse_bits : lock_bits;
            d.en       = 1'b0;
            d.cmd      = CMD_FILL;
        end else if (expire) begin
            d.en  = 1'b0;
            d.cmd = CMD_FILL;
        end

        if (q.busy && op_done) begin
            d.busy = 1'b0;
            d.en   = 1'b0;
            d.cmd  = CMD_FILL;
            if (q.cmd == CMD_WRITE) d.filled = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ie       <= 1'b0;
            q.cmd      <= CMD_FILL;
            q.en       <= 1'b0;
            q.busy     <= 1'b0;
            q.filled   <= 1'b0;
            q.buf_wr   <= 1'b0;
            q.buf_addr <= '0;
            q.buf_data <= '0;
            q.buf_clr  <= 1'b0;
            q.op_start <= 1'b0;
            q.op_kind  <= '0;
            q.op_page  <= '0;
            q.ld_valid <= 1'b0;
            q.ld_data  <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[IE_BIT]  = q.ie;
        reg_rdata[REN_BIT] = (q.cmd == CMD_REN);
        reg_rdata[LBS_BIT] = (q.cmd == CMD_LOCK);
        reg_rdata[PW_BIT]  = (q.cmd == CMD_WRITE);
        reg_rdata[PE_BIT]  = (q.cmd == CMD_ERASE);
        reg_rdata[EN_BIT]  = q.en;
    end

    assign buf_wr   = q.buf_wr;
    assign buf_addr = q.buf_addr;
    assign buf_data = q.buf_data;
    assign buf_clr  = q.buf_clr;
    assign op_start = q.op_start;
    assign op_kind  = q.op_kind;
    assign op_page  = q.op_page;
    assign ld_valid = q.ld_valid;
    assign ld_data  = q.ld_data;
    assign cpu_halt = q.busy;
    assign irq      = q.ie && gie && !q.en;
endmodule

// File: rtl/selfprog_ctrl_chk.sv
module selfprog_ctrl_chk #(
    parameter int ARM_WIN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_rdata,
    input logic       op_start,
    input logic [1:0] op_kind,
    input logic       op_done,
    input logic       cpu_halt,
    input logic       irq
);
    logic [15:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  age_q <= '0;
        else if (!reg_rdata[0] || cpu_halt || reg_wr) age_q <= '0;
        else if (age_q != 16'hFFFF)                  age_q <= age_q + 1'b1;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:5] == 2'b00); // R1

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_rdata[4:1])); // R2

    AST_ARM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && !cpu_halt) |-> (age_q < 16'(ARM_WIN))); // R3

    AST_START_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind != 2'd3) |-> cpu_halt); // R5

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && !op_done) |=> cpu_halt); // R6

    AST_HALT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> reg_rdata[0]); // R6

    AST_REN_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && op_kind == 2'd3) |-> !cpu_halt); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[0] |-> !irq); // R9
endmodule

bind selfprog_ctrl selfprog_ctrl_chk #(.ARM_WIN(ARM_WIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .op_start  (op_start),
    .op_kind   (op_kind),
    .op_done   (op_done),
    .cpu_halt  (cpu_halt),
    .irq       (irq)
);

// File: tb/tb_selfprog_ctrl.sv
module tb_selfprog_ctrl;
    localparam int ZW = 16;
    localparam int PAGE_LSB = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, st_req = 0, ld_req = 0, gie = 0, op_done = 0;
    logic [7:0] reg_wdata = 0, lock_bits = 8'hA5, fuse_bits = 8'h3C;
    logic [ZW-1:0] z_ptr = 0;
    logic [15:0] st_data = 0;
    logic [7:0] reg_rdata, ld_data;
    logic buf_wr, buf_clr, op_start, ld_valid, cpu_halt, irq;
    logic [PAGE_LSB-2:0] buf_addr;
    logic [15:0] buf_data;
    logic [1:0] op_kind;
    logic [ZW-PAGE_LSB-1:0] op_page;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    selfprog_ctrl dut (.*);

    function automatic logic [PAGE_LSB-2:0] exp_idx(input logic [ZW-1:0] z);
        return z[PAGE_LSB-1:1];
    endfunction
    function automatic logic [ZW-PAGE_LSB-1:0] exp_page(input logic [ZW-1:0] z);
        return z[ZW-1:PAGE_LSB];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr(input logic [7:0] v);
        reg_wr = 1; reg_wdata = v; @(negedge clk); reg_wr = 0;
    endtask
    task automatic store(input logic [ZW-1:0] z, input logic [15:0] dat);
        st_req = 1; z_ptr = z; st_data = dat; @(negedge clk); st_req = 0;
    endtask
    task automatic load(input logic [ZW-1:0] z);
        ld_req = 1; z_ptr = z; @(negedge clk); ld_req = 0;
    endtask
    task automatic finish_op();
        op_done = 1; @(negedge clk); op_done = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1));
        idle(3); rst_n = 1; idle(1);
        chk("R1 reset rdata", reg_rdata, 8'h00);
        chk("R1 reset halt/irq", {cpu_halt, irq, buf_wr, op_start, ld_valid}, 0);

        wr(8'h60);
        chk("R1 reserved bits read 0", reg_rdata, 8'h00);

        // R10: store with nothing armed
        store(16'h1234, 16'hBEEF);
        chk("R10 unarmed store", {buf_wr, op_start}, 0);

        // R2 priority
        wr(8'h07); chk("R2 erase over write", reg_rdata, 8'h03);
        wr(8'h1D); chk("R2 write over lock", reg_rdata, 8'h05);
        wr(8'h19); chk("R2 lock over ren", reg_rdata, 8'h09);
        wr(8'h06); chk("R2 no enable disarms", reg_rdata, 8'h00);

        // R3/R4 window edges
        wr(8'h01); idle(3); store(16'h0047, 16'h1111);
        chk("R4 fill at 4th cycle", buf_wr, 1);
        chk("R4 fill index", buf_addr, exp_idx(16'h0047));
        chk("R4 fill data", buf_data, 16'h1111);
        chk("R4 enable cleared", reg_rdata, 8'h00);
        wr(8'h01); idle(4);
        chk("R3 expired", reg_rdata, 8'h00);
        store(16'h0002, 16'h2222);
        chk("R3 late store dropped", buf_wr, 0);

        // R8 buffer clear
        wr(8'h10); chk("R8 clear when filled", buf_clr, 1);
        wr(8'h10); chk("R8 no clear when empty", buf_clr, 0);
        wr(8'h11); chk("R8 ren armed", reg_rdata, 8'h11);
        store(16'hFFC0, 0);
        chk("R8 ren start", {op_start, op_kind, cpu_halt}, {1'b1, 2'd3, 1'b0});
        chk("R8 ren disarmed", reg_rdata, 8'h00);

        // R5/R6 erase
        wr(8'h03); store(16'h1234, 16'hDEAD);
        chk("R5 erase start", {op_start, op_kind, cpu_halt}, {1'b1, 2'd1, 1'b1});
        chk("R5 erase page", op_page, exp_page(16'h1234));
        wr(8'h00); idle(5);
        chk("R6 write ignored while busy", reg_rdata, 8'h03);
        chk("R6 halt held", cpu_halt, 1);
        finish_op();
        chk("R6 done releases", {cpu_halt, reg_rdata}, 9'h000);

        // R5/R6/R8 page write empties buffer
        wr(8'h01); store(16'h0010, 16'h5555);
        wr(8'h05); store(16'h8040, 0);
        chk("R5 write start", {op_start, op_kind, cpu_halt}, {1'b1, 2'd2, 1'b1});
        chk("R5 write page", op_page, exp_page(16'h8040));
        idle(2); finish_op();
        chk("R6 write done", {cpu_halt, reg_rdata}, 9'h000);
        wr(8'h10); chk("R8 buffer empty after page write", buf_clr, 0);

        // R7 lock/fuse read
        wr(8'h09); idle(2); load(16'h0001);
        chk("R7 fuse read", {ld_valid, ld_data}, {1'b1, 8'h3C});
        wr(8'h09); load(16'h0000);
        chk("R7 lock read", {ld_valid, ld_data}, {1'b1, 8'hA5});
        wr(8'h09); idle(3); load(16'h0001);
        chk("R7 late load ignored", ld_valid, 0);
        chk("R7 expired", reg_rdata, 8'h00);

        // R9 interrupt
        gie = 1; wr(8'h80); chk("R9 irq ready", irq, 1);
        wr(8'h81); chk("R9 irq masked while enabled", irq, 0);
        idle(4); chk("R9 irq after expiry", irq, 1);
        gie = 0; #1; chk("R9 irq needs gie", irq, 0);
        wr(8'h00);

        // R3/R4 random fills
        for (int i = 0; i < 60; i++) begin
            logic [ZW-1:0] z = ZW'($urandom);
            logic [15:0] dv = 16'($urandom);
            int dly = $urandom_range(0, 5);
            wr(8'h01); idle(dly); store(z, dv);
            if (dly <= 3) begin
                chk("R4 rand fill", {buf_wr, buf_addr, buf_data}, {1'b1, exp_idx(z), dv});
            end else begin
                chk("R3 rand late drop", buf_wr, 0);
            end
            chk("R3 rand disarmed", reg_rdata, 8'h00);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule